// File: doc/BRIEF.md
# Up/Down Decade Counter with Load

A synchronous modulo-ten counter that holds one BCD digit in the range 0 to 9. A direction input picks the count direction. Upward the digit steps 0, 1, ..., 9 and then returns to 0. Downward it steps 9, 8, ..., 0 and then returns to 9.

An active-low enable gates stepping. An active-low load copies a four-bit word into the digit on the next edge, and load overrides stepping. A terminal flag marks the last state for the present direction: 9 upward, 0 downward. An active-low ripple output repeats that flag during the low half of the clock while counting is enabled. The ripple output lets several digits be chained.

A loaded word from 10 to 15 is not a BCD state. On the following edge without a load, the counter leaves it for a legal state.

Top module: `updn_decade_ctr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cnt` becomes 0. This takes priority over load and counting.
- R2: When `ld_n` is low at a rising edge, `cnt` takes the value of `din`. This holds for any 4-bit value, including 10 to 15, and whatever `cnt_en_n` and `dir_down` are.
- R3: With `dir_down` = 0, `cnt_en_n` = 0 and `ld_n` high, a legal `cnt` rises by one at each edge, and 9 goes to 0.
- R4: With `dir_down` = 1, `cnt_en_n` = 0 and `ld_n` high, a legal `cnt` falls by one at each edge, and 0 goes to 9.
- R5: With `cnt_en_n` high and `ld_n` high, a legal `cnt` keeps its value across the edge.
- R6: `term` is high exactly when (`dir_down` = 0 and `cnt` = 9) or (`dir_down` = 1 and `cnt` = 0). It follows a change of `dir_down` without waiting for a clock.
- R7: `ripple_n` is low exactly when `clk` is low, `cnt_en_n` is low and `term` is high. Otherwise it is high.
- R8: When `cnt` holds 10 to 15 and `ld_n` is high, the next edge sets `cnt` to 0 if `dir_down` = 0 or to 9 if `dir_down` = 1. This happens whatever `cnt_en_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; its low phase also gates `ripple_n` |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| cnt_en_n | input | 1 | Active-low count enable |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4 | Parallel load word |
| cnt | output | 4 | Present BCD digit |
| term | output | 1 | Terminal state for the present direction |
| ripple_n | output | 1 | Active-low chaining pulse |

## Verification
The main check is a table of vectors that mixes runs of upward steps, downward steps, holds and loads. Runs that cross 9 and 0 in both directions show the wrap is direction specific, and a run cannot pass by simply counting binary. Loads placed on the same cycle as an enabled step show that load wins over stepping. Loads of 12 and 15 with the enable off show that recovery from illegal words does not depend on the enable.

At every vector `ripple_n` is sampled in both clock phases, which separates clock gating from gating by the enable. Directed tests then cover reset arriving during a load and a change of direction while the clock is stopped.

// File: rtl/updn_pkg.sv
// Package: shared direction encoding for the decade counter.
// Assumes: one direction bit, 0 meaning upward.
package updn_pkg;
    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/bcd_next.sv
// bcd_next: combinational next-state logic for one modulo-MODULUS digit.
// Assumes: load outranks recovery, recovery outranks the enable,
// and stepping applies only to legal states.
module bcd_next #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_down,
    input  logic             cnt_en_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    import updn_pkg::*;
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic illegal;
    dir_e dir;

    assign illegal = (cur > LAST);
    assign dir     = dir_e'(dir_down);

    // Select the value the digit takes at the next edge.
    always_comb begin
        if (!ld_n)
            nxt = din;
        else if (illegal)
            nxt = (dir == CNT_DOWN) ? LAST : '0;
        else if (cnt_en_n)
            nxt = cur;
        else if (dir == CNT_UP)
            nxt = (cur == LAST) ? '0 : cur + ONE;
        else
            nxt = (cur == '0) ? LAST : cur - ONE;
    end
endmodule

// File: rtl/term_detect.sv
// term_detect: marks the last state for the present direction and builds
// the active-low chaining pulse in the clock's low phase.
// Assumes: the ripple pulse may be combinational on clk by intent.
module term_detect #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_down,
    input  logic             cnt_en_n,
    output logic             term,
    output logic             ripple_n
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    // Terminal decode depends on direction.
    always_comb begin
        term = dir_down ? (cur == '0) : (cur == LAST);
    end

    // Chaining pulse: low while clock low, enabled, and at terminal.
    always_comb begin
        ripple_n = ~(~clk & ~cnt_en_n & term);
    end
endmodule

// File: rtl/updn_decade_ctr.sv
// updn_decade_ctr: synchronous up/down BCD digit with parallel load,
// terminal flag and active-low ripple output for chaining.
// Assumes: reset is synchronous and active low; all inputs settle before
// the rising edge.
module updn_decade_ctr #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_down,
    input  logic             cnt_en_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             term,
    output logic             ripple_n
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    bcd_next #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_next (
        .cur      (state_q),
        .dir_down (dir_down),
        .cnt_en_n (cnt_en_n),
        .ld_n     (ld_n),
        .din      (din),
        .nxt      (state_d)
    );

    term_detect #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_term (
        .clk      (clk),
        .cur      (state_q),
        .dir_down (dir_down),
        .cnt_en_n (cnt_en_n),
        .term     (term),
        .ripple_n (ripple_n)
    );

    // Digit register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt = state_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> cnt == '0);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> cnt == $past(din));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !cnt_en_n && !dir_down && cnt < LAST) |=> cnt == $past(cnt) + ONE);

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !cnt_en_n && !dir_down && cnt == LAST) |=> cnt == '0);

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !cnt_en_n && dir_down && cnt != '0 && cnt <= LAST) |=> cnt == $past(cnt) - ONE);

    // R4
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !cnt_en_n && dir_down && cnt == '0) |=> cnt == LAST);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && cnt_en_n && cnt <= LAST) |=> $stable(cnt));

    // R8
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && cnt > LAST) |=> cnt <= LAST);

    // R7
    always_comb begin
        ripple_term_chk: assert (ripple_n !== 1'b0 || term === 1'b1);
    end
endmodule

// File: tb/sim_updn_decade_ctr.sv
module sim_updn_decade_ctr;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dir_down;
    logic       cnt_en_n;
    logic       ld_n;
    logic [3:0] din;
    logic [3:0] cnt;
    logic       term;
    logic       ripple_n;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    updn_decade_ctr u0 (
        .clk(clk), .rst_n(rst_n), .dir_down(dir_down), .cnt_en_n(cnt_en_n),
        .ld_n(ld_n), .din(din), .cnt(cnt), .term(term), .ripple_n(ripple_n)
    );

    // {ld_n, cnt_en_n, dir_down, din[3:0], exp_cnt[3:0], exp_term}
    localparam int NV = 19;
    localparam logic [11:0] VECS [NV] = '{
        {3'b100, 4'd0,  4'd1,  1'b0},  // R3 up
        {3'b100, 4'd0,  4'd2,  1'b0},  // R3 up
        {3'b010, 4'd7,  4'd7,  1'b0},  // R2 load 7
        {3'b100, 4'd0,  4'd8,  1'b0},  // R3
        {3'b100, 4'd0,  4'd9,  1'b1},  // R3, R6 terminal up
        {3'b100, 4'd0,  4'd0,  1'b0},  // R3 wrap
        {3'b110, 4'd0,  4'd0,  1'b0},  // R5 hold
        {3'b101, 4'd0,  4'd9,  1'b0},  // R4 wrap down
        {3'b101, 4'd0,  4'd8,  1'b0},  // R4
        {3'b011, 4'd1,  4'd1,  1'b0},  // R2 load 1
        {3'b101, 4'd0,  4'd0,  1'b1},  // R4, R6 terminal down
        {3'b111, 4'd0,  4'd0,  1'b1},  // R5 hold at terminal
        {3'b101, 4'd0,  4'd9,  1'b0},  // R4 wrap
        {3'b000, 4'd12, 4'd12, 1'b0},  // R2 load illegal
        {3'b110, 4'd0,  4'd0,  1'b0},  // R8 recover up, disabled
        {3'b011, 4'd15, 4'd15, 1'b0},  // R2 load 15
        {3'b111, 4'd0,  4'd9,  1'b0},  // R8 recover down, disabled
        {3'b000, 4'd9,  4'd9,  1'b1},  // R2 load over enabled step
        {3'b110, 4'd0,  4'd9,  1'b1}   // R5 hold
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dir_down = 1'b0; cnt_en_n = 1'b1; ld_n = 1'b1; din = 4'd0;
        @(posedge clk); @(posedge clk); #3;
        chk("R1 reset", cnt, 0);
        @(negedge clk); #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ld_n     = VECS[i][11];
            cnt_en_n = VECS[i][10];
            dir_down = VECS[i][9];
            din      = VECS[i][8:5];
            @(posedge clk); #3;
            chk("R2/R3/R4/R5/R8 cnt", cnt, VECS[i][4:1]);
            chk("R6 term", term, VECS[i][0]);
            chk("R7 ripple clk high", ripple_n, 1);
            @(negedge clk); #1;
            chk("R7 ripple clk low", ripple_n, !(VECS[i][0] && !cnt_en_n));
        end

        // R6: direction change at a hold moves term without a clock
        ld_n = 1'b0; din = 4'd0; cnt_en_n = 1'b1; dir_down = 1'b0;
        @(posedge clk); #3;
        ld_n = 1'b1;
        chk("R6 term up at 0", term, 0);
        dir_down = 1'b1; #1;
        chk("R6 term down at 0", term, 1);
        chk("R7 ripple disabled", ripple_n, 1);

        // R1: reset beats load and enabled step
        @(negedge clk); #1;
        ld_n = 1'b0; din = 4'd6; cnt_en_n = 1'b0; rst_n = 1'b0;
        @(posedge clk); #3;
        chk("R1 reset over load", cnt, 0);
        @(negedge clk); #1;
        rst_n = 1'b1; ld_n = 1'b1; dir_down = 1'b0;
        @(posedge clk); #3;
        chk("R3 count after reset", cnt, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end
endmodule